// File: doc/BRIEF.md
# Disk Controller Status and Interrupt Aggregator

This block recomputes the two status words of a multi-drive disk pack controller every time the controller logs an event. The surrounding logic presents the current contents of both status words, the flag bits the event raises, and the state of the drive that is currently selected. The selected drive's state is whether it is attached, whether it is write-locked, whether it has a command in flight, whether that command is a positioning one, and which cylinder it sits on. The block returns the refreshed words in the same cycle. The controller writes them back into its own registers.

Each refresh does three things. It drops the per-drive bits and the composite error bit carried over from the previous state, merges in the new event bits, and rebuilds the per-drive bits from whichever drive is selected now. It then forms the composite error bit as an OR over a fixed set of error flags in both words. It also drives two outputs. The first is a registered interrupt request, gated by two separate enables: one for completion or error, one for attention. The second is an unregistered attention line that ignores those enables.

The event input is a plain single-cycle strobe with no back-pressure: every strobe is accepted and acted on. The status outputs are a pure function of the inputs. The interrupt request only changes on a clock edge that sees the strobe.

Top module: `dstat_aggr`

## Requirements
- R1: Before merging, the block discards bits 3, 2 and 0 of the incoming status A word and bits 9, 1 and 0 of the incoming status B word. These are the selected-drive write-lock, seek-incomplete, error, unsafe, seeking and not-ready bits. None of them reaches the output unless this refresh sets it again.
- R2: All other incoming bits pass to the outputs unchanged. The event vectors `set_a` and `set_b` are ORed into status A and status B. Status A bits 17:15 select the drive and bits 14:12 hold the function.
- R3: A write-locked selected drive sets status A bit 3, whatever its other state.
- R4: An unattached selected drive sets status B bit 9 (unsafe) and bit 0 (not ready). It never sets status B bit 1 or status A bit 2.
- R5: An attached drive with a command in flight sets status B bit 1 (seeking) and bit 0 (not ready) only when the command is a seek or recalibrate. Any other command in flight sets neither bit.
- R6: An attached drive with no command in flight sets status A bit 2 (seek incomplete) when its cylinder is at or above `NUM_CYL` (203 by default). Cylinder 202 does not set it.
- R7: Output status A bit 0 is 1 exactly when at least one error flag is 1. The status A error flags are bits 8, 7, 6, 5, 4 and 2. The status B error flags are bits 9 down to 2.
- R8: On the rising edge that sees `upd` high, `irq` loads 1 in either of two cases: output status A bit 0 or bit 1 (done) is set while status A bit 11 (done/error enable) is set; or any status B bit 17:10 (attention) is set while status A bit 10 (attention enable) is set. Otherwise it loads 0. Without `upd`, `irq` holds its value.
- R9: `ios` is high whenever output status A bit 0, output status A bit 1 or any output status B bit 17:10 is set, whatever the two enables.
- R10: Synchronous active-low reset drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd | input | 1 | Event strobe; loads the interrupt register |
| sta_in | input | 18 | Current status A word |
| stb_in | input | 18 | Current status B word |
| set_a | input | 18 | Event flags to OR into status A |
| set_b | input | 18 | Event flags to OR into status B |
| unit_attached | input | 1 | Selected drive has media attached |
| unit_wlock | input | 1 | Selected drive is write-locked |
| unit_active | input | 1 | Selected drive has a command in flight |
| unit_seeking | input | 1 | The in-flight command is seek or recalibrate |
| unit_cyl | input | 8 | Current cylinder of the selected drive |
| sta_out | output | 18 | Refreshed status A word |
| stb_out | output | 18 | Refreshed status B word |
| irq | output | 1 | Registered interrupt request |
| ios | output | 1 | Unregistered attention/status line |

## Verification
On every cycle, the assertions check the following: the composite error bit agrees with the error flags of both output words; a detached or write-locked drive always shows its flags; seek-incomplete appears only for an attached idle drive; the per-drive bits in both words exclude one another; and `irq` moves only on a strobe edge, needs an enable and implies `ios`. Other behaviour is shown only by the scoreboard scenarios. These cover the clearing of stale per-drive bits, the pass-through of unrelated fields, and the exact boundary at cylinder 203. They also cover positioning versus transfer commands in flight, and attention raising `ios` while the enables keep `irq` low.

// File: rtl/dstat_pkg.sv
package dstat_pkg;
  localparam int REG_W = 18;
  typedef logic [REG_W-1:0] stat_word_t;

  // status A bit positions (decoded by neighbouring logic)
  localparam int A_IE_DONE  = 11;
  localparam int A_IE_ATTN  = 10;
  localparam int A_WLERR    = 8;
  localparam int A_NOCYL    = 7;
  localparam int A_NOSURF   = 6;
  localparam int A_NOSECT   = 5;
  localparam int A_NOHDR    = 4;
  localparam int A_SELWL    = 3;
  localparam int A_SEEKINC  = 2;
  localparam int A_DONE     = 1;
  localparam int A_ERR      = 0;

  // status B bit positions
  localparam int B_UNSAFE   = 9;
  localparam int B_SEEKING  = 1;
  localparam int B_NOTRDY   = 0;

  localparam stat_word_t A_ERR_MASK =
    stat_word_t'((1 << A_WLERR) | (1 << A_NOCYL) | (1 << A_NOSURF) |
                 (1 << A_NOSECT) | (1 << A_NOHDR) | (1 << A_SEEKINC));
  localparam stat_word_t B_ERR_MASK = stat_word_t'(18'h003FC);
  localparam stat_word_t A_DYN_MASK =
    stat_word_t'((1 << A_SELWL) | (1 << A_SEEKINC) | (1 << A_ERR));
  localparam stat_word_t B_DYN_MASK =
    stat_word_t'((1 << B_UNSAFE) | (1 << B_SEEKING) | (1 << B_NOTRDY));
endpackage

// File: rtl/dstat_unit_dyn.sv
module dstat_unit_dyn
  import dstat_pkg::*;
#(
  parameter int CYL_W   = 8,
  parameter int NUM_CYL = 203
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             attached,
  input  logic             wlock,
  input  logic             active,
  input  logic             seeking,
  input  logic [CYL_W-1:0] cyl,
  output stat_word_t       dyn_a,
  output stat_word_t       dyn_b
);
  localparam logic [CYL_W:0] CYL_LIMIT = (CYL_W+1)'(NUM_CYL);

  logic past_end;
  assign past_end = {1'b0, cyl} >= CYL_LIMIT;

  always_comb begin
    dyn_a = '0;
    dyn_b = '0;
    dyn_a[A_SELWL] = wlock;
    if (!attached) begin
      dyn_b[B_UNSAFE] = 1'b1;
      dyn_b[B_NOTRDY] = 1'b1;
    end else if (active) begin
      if (seeking) begin
        dyn_b[B_SEEKING] = 1'b1;
        dyn_b[B_NOTRDY]  = 1'b1;
      end
    end else if (past_end) begin
      dyn_a[A_SEEKINC] = 1'b1;
    end
  end

  // the three drive-state branches exclude one another
  AST_DYN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dyn_a[A_SEEKINC], dyn_b[B_SEEKING], dyn_b[B_UNSAFE]})); // R5
endmodule

// File: rtl/dstat_merge.sv
module dstat_merge
  import dstat_pkg::*;
(
  input  stat_word_t sta_in,
  input  stat_word_t stb_in,
  input  stat_word_t set_a,
  input  stat_word_t set_b,
  input  stat_word_t dyn_a,
  input  stat_word_t dyn_b,
  output stat_word_t sta_pre,
  output stat_word_t stb_pre
);
  always_comb begin
    sta_pre = (sta_in & ~A_DYN_MASK) | set_a | dyn_a;
    stb_pre = (stb_in & ~B_DYN_MASK) | set_b | dyn_b;
  end
endmodule

// File: rtl/dstat_err_sum.sv
module dstat_err_sum
  import dstat_pkg::*;
(
  input  stat_word_t sta_pre,
  input  stat_word_t stb_pre,
  output logic       err
);
  assign err = (|(sta_pre & A_ERR_MASK)) | (|(stb_pre & B_ERR_MASK));
endmodule

// File: rtl/dstat_irq.sv
module dstat_irq
  import dstat_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  stat_word_t sta,
  input  stat_word_t stb,
  output logic       irq,
  output logic       ios
);
  localparam int ATTN_LO = REG_W - NUM_UNITS;

  logic attn_any, done_err, irq_next;
  assign attn_any = |stb[REG_W-1:ATTN_LO];
  assign done_err = sta[A_ERR] | sta[A_DONE];
  assign ios      = done_err | attn_any;
  assign irq_next = (done_err & sta[A_IE_DONE]) | (attn_any & sta[A_IE_ATTN]);

  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (upd) irq <= irq_next;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(irq)); // R8
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd ##1 irq |-> $past(sta[A_IE_DONE] | sta[A_IE_ATTN])); // R8
  AST_IRQ_IMPLIES_IOS: assert property (@(posedge clk) disable iff (!rst_n)
    upd ##1 irq |-> $past(ios)); // R9
endmodule

// File: rtl/dstat_aggr.sv
module dstat_aggr
  import dstat_pkg::*;
#(
  parameter int CYL_W     = 8,
  parameter int NUM_CYL   = 203,
  parameter int NUM_UNITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [17:0]      sta_in,
  input  logic [17:0]      stb_in,
  input  logic [17:0]      set_a,
  input  logic [17:0]      set_b,
  input  logic             unit_attached,
  input  logic             unit_wlock,
  input  logic             unit_active,
  input  logic             unit_seeking,
  input  logic [CYL_W-1:0] unit_cyl,
  output logic [17:0]      sta_out,
  output logic [17:0]      stb_out,
  output logic             irq,
  output logic             ios
);
  stat_word_t dyn_a, dyn_b, sta_pre, stb_pre;
  logic       err;

  dstat_unit_dyn #(.CYL_W(CYL_W), .NUM_CYL(NUM_CYL)) u_dyn (
    .clk(clk), .rst_n(rst_n),
    .attached(unit_attached), .wlock(unit_wlock), .active(unit_active),
    .seeking(unit_seeking), .cyl(unit_cyl),
    .dyn_a(dyn_a), .dyn_b(dyn_b)
  );

  dstat_merge u_merge (
    .sta_in(sta_in), .stb_in(stb_in), .set_a(set_a), .set_b(set_b),
    .dyn_a(dyn_a), .dyn_b(dyn_b), .sta_pre(sta_pre), .stb_pre(stb_pre)
  );

  dstat_err_sum u_err (.sta_pre(sta_pre), .stb_pre(stb_pre), .err(err));

  always_comb begin
    sta_out        = sta_pre;
    sta_out[A_ERR] = sta_pre[A_ERR] | err;
    stb_out        = stb_pre;
  end

  dstat_irq #(.NUM_UNITS(NUM_UNITS)) u_irq (
    .clk(clk), .rst_n(rst_n), .upd(upd),
    .sta(sta_out), .stb(stb_out), .irq(irq), .ios(ios)
  );

  AST_DETACHED_UNSAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_attached |-> stb_out[B_UNSAFE] && stb_out[B_NOTRDY] && !stb_out[B_SEEKING]); // R4
  AST_WLOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    unit_wlock |-> sta_out[A_SELWL]); // R3
  AST_SEEKINC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_out[A_SEEKINC] && !set_a[A_SEEKINC]) |-> unit_attached && !unit_active); // R6
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(sta_out & A_ERR_MASK)) || (|(stb_out & B_ERR_MASK))) |-> sta_out[A_ERR]); // R7
endmodule

// File: tb/sim_dstat_aggr.sv
module sim_dstat_aggr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic [17:0] sta_in = '0, stb_in = '0, set_a = '0, set_b = '0;
  logic unit_attached = 1'b1, unit_wlock = 1'b0, unit_active = 1'b0, unit_seeking = 1'b0;
  logic [7:0] unit_cyl = '0;
  logic [17:0] sta_out, stb_out;
  logic irq, ios;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  dstat_aggr u0 (
    .clk(clk), .rst_n(rst_n), .upd(upd),
    .sta_in(sta_in), .stb_in(stb_in), .set_a(set_a), .set_b(set_b),
    .unit_attached(unit_attached), .unit_wlock(unit_wlock),
    .unit_active(unit_active), .unit_seeking(unit_seeking), .unit_cyl(unit_cyl),
    .sta_out(sta_out), .stb_out(stb_out), .irq(irq), .ios(ios)
  );

  typedef struct {
    logic [17:0] a;
    logic [17:0] b;
    logic        io;
    logic        ir;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // expected model written from the requirements
  function automatic exp_t model(input string tag);
    exp_t e;
    e.a = (sta_in & ~18'h0000D) | set_a;                 // R1, R2
    e.b = (stb_in & ~18'h00203) | set_b;
    if (unit_wlock) e.a[3] = 1'b1;                       // R3
    if (!unit_attached) begin e.b[9] = 1'b1; e.b[0] = 1'b1; end // R4
    else if (unit_active) begin
      if (unit_seeking) begin e.b[1] = 1'b1; e.b[0] = 1'b1; end // R5
    end else if (unit_cyl >= 8'd203) e.a[2] = 1'b1;      // R6
    if ((e.a & 18'h001F4) != 0 || (e.b & 18'h003FC) != 0) e.a[0] = 1'b1; // R7
    e.io = e.a[0] | e.a[1] | (|e.b[17:10]);              // R9
    e.ir = ((e.a[0] | e.a[1]) & e.a[11]) | ((|e.b[17:10]) & e.a[10]); // R8
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input string tag,
                       input logic [17:0] sa, input logic [17:0] sbw,
                       input logic [17:0] ea, input logic [17:0] eb,
                       input logic att, input logic wl, input logic act,
                       input logic sk, input logic [7:0] cy);
    @(negedge clk);
    sta_in = sa; stb_in = sbw; set_a = ea; set_b = eb;
    unit_attached = att; unit_wlock = wl; unit_active = act;
    unit_seeking = sk; unit_cyl = cy; upd = 1'b1;
    sb_q.push_back(model(tag));
  endtask

  // monitor: status at the strobe edge, irq half a cycle later
  initial begin
    forever begin
      @(posedge clk);
      if (upd && rst_n) begin
        logic [17:0] ga, gb;
        logic gio;
        exp_t e;
        ga = sta_out; gb = stb_out; gio = ios;
        @(negedge clk);
        #1;
        if (sb_q.size() == 0) begin
          check("monitor: unexpected result", 1, 0);
        end else begin
          e = sb_q.pop_front();
          check({e.tag, " sta_out"}, 32'(ga), 32'(e.a));
          check({e.tag, " stb_out"}, 32'(gb), 32'(e.b));
          check({e.tag, " ios"},     32'(gio), 32'(e.io));
          check({e.tag, " irq"},     32'(irq), 32'(e.ir));
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset irq", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 irq after reset", 32'(irq), 0);

    drive("R2 quiet",          18'h0, 18'h0, 18'h0, 18'h0, 1, 0, 0, 0, 8'd0);
    drive("R1 stale cleared",  18'h0000D, 18'h00203, 18'h0, 18'h0, 1, 0, 0, 0, 8'd5);
    drive("R2 fields pass",    18'o777000, 18'h0, 18'h00002, 18'h0, 1, 0, 0, 0, 8'd9);
    drive("R3 write lock",     18'h0, 18'h0, 18'h0, 18'h0, 1, 1, 0, 0, 8'd0);
    drive("R4 detached",       18'h00800, 18'h0, 18'h0, 18'h0, 0, 0, 1, 1, 8'd250);
    drive("R5 seeking",        18'h0, 18'h0, 18'h0, 18'h0, 1, 0, 1, 1, 8'd17);
    drive("R5 transfer",       18'h0, 18'h0, 18'h0, 18'h0, 1, 0, 1, 0, 8'd250);
    drive("R6 cyl 203",        18'h0, 18'h0, 18'h0, 18'h0, 1, 0, 0, 0, 8'd203);
    drive("R6 cyl 202",        18'h0, 18'h0, 18'h0, 18'h0, 1, 0, 0, 0, 8'd202);
    drive("R7 B format err",   18'h00800, 18'h0, 18'h0, 18'h00020, 1, 0, 0, 0, 8'd0);
    drive("R7 A hdr err",      18'h0, 18'h0, 18'h00010, 18'h0, 1, 0, 0, 0, 8'd0);
    drive("R8 attention irq",  18'h00400, 18'h0, 18'h0, 18'h20000, 1, 0, 0, 0, 8'd0);
    drive("R9 attn no enable", 18'h0, 18'h00400, 18'h0, 18'h0, 1, 0, 0, 0, 8'd0);
    drive("R8 done enabled",   18'h00800, 18'h0, 18'h00002, 18'h0, 1, 0, 0, 0, 8'd0);
    drive("R8 done wrong en",  18'h00400, 18'h0, 18'h00002, 18'h0, 1, 0, 0, 0, 8'd0);
    drive("R8 set then hold",  18'h00800, 18'h0, 18'h00002, 18'h0, 1, 0, 0, 0, 8'd0);

    @(negedge clk);
    upd = 1'b0;
    set_a = '0; sta_in = '0;
    repeat (2) @(negedge clk);
    // R8: without a strobe irq keeps the 1 loaded above
    check("R8 hold without upd", 32'(irq), 1);
    // R9: ios follows the words combinationally
    check("R9 ios quiet", 32'(ios), 0);

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(sb_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule